// File: doc/BRIEF.md
# Character Bank and Nametable Mirroring Mapper

This block turns a pattern-table address from the video side into a physical address in character memory and also derives the one-bit nametable select that a mirroring scheme produces. Two layouts are supported. In split mode the lower and upper 4 KB halves of the pattern space each take their bank from a separate bank register. In unified mode one 8 KB window is used, and it is numbered by the first bank register with its lowest bit dropped. The nametable select comes from video address bit 10, from bit 11, or is held at a constant for the two single-screen arrangements.

Lookups arrive as a valid/ready stream and leave as a registered valid/ready stream with a latency of one cycle. An upstream request is accepted when `req_valid_i` and `req_ready_o` are both high. The mode and bank inputs are sampled on that same edge. While a response waits with `rsp_ready_i` low, the response is held unchanged and `req_ready_o` stays low. When the consumer takes a response, a new request can be accepted on the same edge.

The fitted character memory is set by a parameter as a count of 4 KB banks, and bank numbers are masked to that count. A board built without character ROM instead has 8 KB of writable character RAM, which means two 4 KB banks.

Top module: `chr_nt_mapper`

## Requirements
- R1: When `ctrl_split_i`=1, addresses 0x0000–0x0FFF map to bank `chr_bank_a_i` and addresses 0x1000–0x1FFF map to bank `chr_bank_b_i`. The physical address is {bank, vaddr[11:0]}.
- R2: When `ctrl_split_i`=0, the physical address is {`chr_bank_a_i`>>1, vaddr[12:0]}. Bit 0 of `chr_bank_a_i` and all of `chr_bank_b_i` have no effect.
- R3: `ctrl_mirror_i`=2 (vertical) gives a nametable select equal to vaddr bit 10. `ctrl_mirror_i`=3 (horizontal) gives a select equal to vaddr bit 11.
- R4: `ctrl_mirror_i`=0 gives a constant select of 0 (single-screen lower). `ctrl_mirror_i`=1 gives a constant select of 1 (single-screen upper).
- R5: The 4 KB bank number is ANDed with CHR_BANKS_4K-1, so bank bits beyond the fitted memory are ignored.
- R6: With CHR_RAM=1 the mapper addresses only 8 KB: the 4 KB bank number is ANDed with 1 and all higher address bits read 0.
- R7: A request accepted on a clock edge produces `rsp_valid_o`=1 with its result after that edge.
- R8: While `rsp_valid_o`=1 and `rsp_ready_i`=0, `req_ready_o` is 0 and the response fields stay stable. Changes to the mode or bank inputs during that time do not alter the held response.
- R9: After reset `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_split_i | input | 1 | 1: two 4 KB banks, 0: one 8 KB bank |
| ctrl_mirror_i | input | 2 | Mirroring code (0 lower, 1 upper, 2 vertical, 3 horizontal) |
| chr_bank_a_i | input | 5 | First character bank register |
| chr_bank_b_i | input | 5 | Second character bank register |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted when high |
| req_vaddr_i | input | 13 | Video address, low 13 bits |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer ready for the response |
| rsp_chr_addr_o | output | CADDR_W (16 at CHR_BANKS_4K=16) | Physical character memory address |
| rsp_nt_sel_o | output | 1 | Nametable select |

## Verification
The hardest case to reach is a stalled response while the bank and mode inputs change underneath it. The register values must be captured at acceptance, not read later, when the response drains. The stimulus holds `rsp_ready_i` low and offers a second request with different registers. It then checks over several cycles that the first result holds and that the request is refused. Finally it releases the consumer and checks that the second request is taken on the draining edge. Masking is reached by loading bank values above the fitted bank count, and a second instance built as RAM-only shows the 8 KB limit.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int BANK_W  = 5;
  localparam int VADDR_W = 13;
  localparam int PAGE_W  = 12;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORIZ  = 2'd3
  } mirror_e;
endpackage

// File: rtl/chr_bank_sel.sv
module chr_bank_sel
  import chr_map_pkg::*;
#(
  parameter int NBANKS  = 16,
  parameter int CADDR_W = 16
) (
  input  logic               split_i,
  input  logic [BANK_W-1:0]  bank_a_i,
  input  logic [BANK_W-1:0]  bank_b_i,
  input  logic [VADDR_W-1:0] vaddr_i,
  output logic [CADDR_W-1:0] addr_o
);
  localparam int BSEL_W = CADDR_W - PAGE_W;
  localparam int EXT_W  = BANK_W + BSEL_W;
  localparam logic [BANK_W-1:0] MASK = BANK_W'(NBANKS - 1);

  logic [BANK_W-1:0] bank4;
  logic [BANK_W-1:0] bank_m;
  logic [EXT_W-1:0]  bank_ext;

  always_comb begin
    if (split_i)
      bank4 = vaddr_i[PAGE_W] ? bank_b_i : bank_a_i;
    else
      bank4 = {bank_a_i[BANK_W-1:1], vaddr_i[PAGE_W]};
    bank_m   = bank4 & MASK;
    bank_ext = EXT_W'(bank_m);
  end

  assign addr_o = {bank_ext[BSEL_W-1:0], vaddr_i[PAGE_W-1:0]};
endmodule

// File: rtl/nt_mirror_sel.sv
module nt_mirror_sel
  import chr_map_pkg::*;
(
  input  logic [1:0]         mode_i,
  input  logic [VADDR_W-1:0] vaddr_i,
  output logic               sel_o
);
  mirror_e mode;
  assign mode = mirror_e'(mode_i);

  always_comb begin
    unique case (mode)
      MIR_ONE_LO: sel_o = 1'b0;
      MIR_ONE_HI: sel_o = 1'b1;
      MIR_VERT:   sel_o = vaddr_i[10];
      MIR_HORIZ:  sel_o = vaddr_i[11];
      default:    sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlate_pipe.sv
module xlate_pipe #(
  parameter int DATA_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end
endmodule

// File: rtl/chr_nt_mapper.sv
module chr_nt_mapper
  import chr_map_pkg::*;
#(
  parameter int CHR_BANKS_4K = 32,
  parameter bit CHR_RAM      = 1'b0,
  localparam int CADDR_W     = PAGE_W + $clog2(CHR_BANKS_4K)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_split_i,
  input  logic [1:0]         ctrl_mirror_i,
  input  logic [BANK_W-1:0]  chr_bank_a_i,
  input  logic [BANK_W-1:0]  chr_bank_b_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VADDR_W-1:0] req_vaddr_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [CADDR_W-1:0] rsp_chr_addr_o,
  output logic               rsp_nt_sel_o
);
  localparam int EFF_BANKS = CHR_RAM ? 2 : CHR_BANKS_4K;
  localparam int DATA_W    = CADDR_W + 1;

  logic [CADDR_W-1:0] addr_c;
  logic               nt_c;
  logic [DATA_W-1:0]  out_data;

  chr_bank_sel #(.NBANKS(EFF_BANKS), .CADDR_W(CADDR_W)) u_bank (
    .split_i (ctrl_split_i),
    .bank_a_i(chr_bank_a_i),
    .bank_b_i(chr_bank_b_i),
    .vaddr_i (req_vaddr_i),
    .addr_o  (addr_c)
  );

  nt_mirror_sel u_mir (
    .mode_i (ctrl_mirror_i),
    .vaddr_i(req_vaddr_i),
    .sel_o  (nt_c)
  );

  xlate_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (req_valid_i),
    .in_ready_o (req_ready_o),
    .in_data_i  ({addr_c, nt_c}),
    .out_valid_o(rsp_valid_o),
    .out_ready_i(rsp_ready_i),
    .out_data_o (out_data)
  );

  assign rsp_chr_addr_o = out_data[DATA_W-1:1];
  assign rsp_nt_sel_o   = out_data[0];
endmodule

// File: rtl/chr_nt_mapper_chk.sv
module chr_nt_mapper_chk #(
  parameter int CADDR_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         ctrl_mirror_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [12:0]        req_vaddr_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [CADDR_W-1:0] rsp_chr_addr_o,
  input logic               rsp_nt_sel_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  p_fire_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid_o);

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_chr_addr_o) && $stable(rsp_nt_sel_o)));

  p_page_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_chr_addr_o[11:0] == $past(req_vaddr_i[11:0]));

  p_single_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl_mirror_i == 2'd0) |=> !rsp_nt_sel_o);

  p_single_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl_mirror_i == 2'd1) |=> rsp_nt_sel_o);

  p_vert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl_mirror_i == 2'd2) |=> rsp_nt_sel_o == $past(req_vaddr_i[10]));

  p_horiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl_mirror_i == 2'd3) |=> rsp_nt_sel_o == $past(req_vaddr_i[11]));
endmodule

bind chr_nt_mapper chr_nt_mapper_chk #(.CADDR_W(CADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_mirror_i (ctrl_mirror_i),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_vaddr_i   (req_vaddr_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_chr_addr_o(rsp_chr_addr_o),
  .rsp_nt_sel_o  (rsp_nt_sel_o)
);

// File: tb/tb_chr_nt_mapper.sv
module tb_chr_nt_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split = 1'b0;
  logic [1:0]  mir = 2'd0;
  logic [4:0]  bank_a = '0, bank_b = '0;
  logic        req_valid = 1'b0;
  logic [12:0] vaddr = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, nt;
  logic [15:0] addr;
  logic        req_ready_r, rsp_valid_r, nt_r;
  logic [15:0] addr_r;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  chr_nt_mapper #(.CHR_BANKS_4K(16)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_split_i(split), .ctrl_mirror_i(mir),
    .chr_bank_a_i(bank_a), .chr_bank_b_i(bank_b), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_vaddr_i(vaddr), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_chr_addr_o(addr), .rsp_nt_sel_o(nt));

  chr_nt_mapper #(.CHR_BANKS_4K(16), .CHR_RAM(1'b1)) dut_ram (
    .clk(clk), .rst_n(rst_n), .ctrl_split_i(split), .ctrl_mirror_i(mir),
    .chr_bank_a_i(bank_a), .chr_bank_b_i(bank_b), .req_valid_i(req_valid),
    .req_ready_o(req_ready_r), .req_vaddr_i(vaddr), .rsp_valid_o(rsp_valid_r),
    .rsp_ready_i(rsp_ready), .rsp_chr_addr_o(addr_r), .rsp_nt_sel_o(nt_r));

  // {split, mirror, bank_a, bank_b, vaddr, exp_addr, exp_nt}
  localparam int NV = 12;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd3,  5'd7,  13'h0123, 16'h3123, 1'b0},  // R1 low half
    {1'b1, 2'd0, 5'd3,  5'd7,  13'h1ABC, 16'h7ABC, 1'b0},  // R1 high half
    {1'b0, 2'd0, 5'd5,  5'd9,  13'h0456, 16'h4456, 1'b0},  // R2
    {1'b0, 2'd0, 5'd5,  5'd9,  13'h1456, 16'h5456, 1'b0},  // R2
    {1'b0, 2'd2, 5'd0,  5'd0,  13'h0C00, 16'h0C00, 1'b1},  // R3 vertical
    {1'b0, 2'd2, 5'd0,  5'd0,  13'h0800, 16'h0800, 1'b0},  // R3 vertical
    {1'b0, 2'd3, 5'd0,  5'd0,  13'h0800, 16'h0800, 1'b1},  // R3 horizontal
    {1'b0, 2'd3, 5'd0,  5'd0,  13'h0400, 16'h0400, 1'b0},  // R3 horizontal
    {1'b0, 2'd1, 5'd0,  5'd0,  13'h0000, 16'h0000, 1'b1},  // R4 upper
    {1'b1, 2'd1, 5'h1F, 5'h12, 13'h0FFF, 16'hFFFF, 1'b1},  // R5 mask
    {1'b1, 2'd1, 5'h1F, 5'h12, 13'h1000, 16'h2000, 1'b1},  // R5 mask
    {1'b0, 2'd0, 5'h1F, 5'h00, 13'h1FFF, 16'hFFFF, 1'b0}   // R5 mask
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic s, input logic [1:0] m, input logic [4:0] a,
                      input logic [4:0] b, input logic [12:0] v);
    @(negedge clk);
    split = s; mir = m; bank_a = a; bank_b = b; vaddr = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rsp_valid == 1'b0, "R9 rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R9 req_ready", 32'(req_ready), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][42], VEC[i][41:40], VEC[i][39:35], VEC[i][34:30], VEC[i][29:17]);
      chk(rsp_valid == 1'b1, "R7 valid", 32'(rsp_valid), 1);
      chk(addr == VEC[i][16:1], $sformatf("R1/R2/R5 addr vec%0d", i), 32'(addr), 32'(VEC[i][16:1]));
      chk(nt == VEC[i][0], $sformatf("R3/R4 nt vec%0d", i), 32'(nt), 32'(VEC[i][0]));
    end

    // R4 single-screen lower with address bits 10 and 11 set
    send(1'b0, 2'd0, 5'd0, 5'd0, 13'h0C00);
    chk(nt == 1'b0, "R4 lower", 32'(nt), 0);

    // R6 RAM-only variant limited to 8 KB
    send(1'b1, 2'd2, 5'd5, 5'd6, 13'h0010);
    chk(addr_r == 16'h1010, "R6 split low", 32'(addr_r), 32'h1010);
    send(1'b1, 2'd2, 5'd5, 5'd6, 13'h1010);
    chk(addr_r == 16'h0010, "R6 split high", 32'(addr_r), 32'h0010);
    send(1'b0, 2'd2, 5'h1F, 5'd0, 13'h1234);
    chk(addr_r == 16'h1234, "R6 unified", 32'(addr_r), 32'h1234);

    // R8 stall: response held, new registers must not leak in
    @(negedge clk);
    rsp_ready = 1'b0;
    split = 1'b1; mir = 2'd1; bank_a = 5'd4; bank_b = 5'd9; vaddr = 13'h0ABC; req_valid = 1'b1;
    @(negedge clk);
    chk(rsp_valid && addr == 16'h4ABC, "R8 first", 32'(addr), 32'h4ABC);
    split = 1'b0; mir = 2'd0; bank_a = 5'd8; vaddr = 13'h0111;
    repeat (3) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 ready low", 32'(req_ready), 0);
      chk(addr == 16'h4ABC && nt == 1'b1, "R8 hold", 32'(addr), 32'h4ABC);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && addr == 16'h8111 && nt == 1'b0, "R8 drain", 32'(addr), 32'h8111);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 idle", 32'(rsp_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule